// File: doc/BRIEF.md
# SPI Flash Command Shift Engine

This block is a register-programmed SPI master that carries out one serial-flash command each time it is started. Software loads a command word (an opcode in the low byte and a 24-bit flash address above it) and a 32-bit data word. It then writes a control word that holds a send byte count, a receive byte count and a start bit. The engine pulls chip select low and sends the bytes. It then clocks in the requested number of reply bytes and drops them into the data word, where software reads them back.

The outgoing bytes always come in the same order: the opcode, then the address bytes with the most significant byte first, then the data bytes with the least significant byte first. Every byte is sent most significant bit first. Receiving starts only after the last sent byte. The link runs in SPI mode 0 with one chip select, and each SPI half period lasts `HALF_DIV` system clocks.

Top module: `spi_flash_engine`

## Requirements
- R1: Reset, which is synchronous and active low, leaves `cs_n` high, `sck` low, `busy` low, and both `cmd_o` and `data_o` at zero.
- R2: A write with `wr_sel`=0 loads the command word, visible on `cmd_o`. `wr_sel`=1 loads the data word, visible on `data_o`. `wr_sel`=2 is the control word. A write with `wr_sel`=3 changes nothing.
- R3: A control write with bit 0 set, made while idle, starts a transaction. After that clock edge `busy` is high, `cs_n` is low and `sck` is still low.
- R4: Send byte k is chosen as follows. k=0 is `cmd[7:0]`. k=1, 2 and 3 are `cmd[31:24]`, `cmd[23:16]` and `cmd[15:8]`. k=4 to 7 are `data[8(k-4)+7:8(k-4)]`. Each byte goes out MSB first.
- R5: The send count is control bits 11:8. A value of 0 is treated as 1, and any value above 8 is treated as 8.
- R6: The receive count is control bits 18:16, and any value above 4 is treated as 4. Reply bytes follow the sent bytes, and `mosi` is low while they are clocked in. Reply byte j replaces `data[8j+7:8j]`. Lanes not received keep their value, so a zero count leaves the data word unchanged.
- R7: The link uses mode 0. `sck` is low whenever `cs_n` is high. `mosi` changes only while `sck` is low. `miso` is captured at each rising edge of `sck`.
- R8: Counted in system clocks from the starting edge, with N = send count + receive count after limiting: the first `sck` rise comes after 2·HALF_DIV clocks; `cs_n` rises after HALF_DIV·(16N+2) clocks; `busy` falls after HALF_DIV·(16N+4) clocks. This leaves at least one idle SPI clock between transactions.
- R9: While `busy` is high, the engine ignores every write: start requests, command words and data words.
- R10: Each transaction produces exactly 8N rising edges of `sck`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 command, 1 data, 2 control |
| wr_data | input | 32 | Write value |
| cmd_o | output | 32 | Current command word |
| data_o | output | 32 | Current data word, including received bytes |
| busy | output | 1 | Transaction in progress |
| sck | output | 1 | SPI clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
All timing counts start from the clock edge that accepts the control write. The first `sck` rise is due 2·HALF_DIV clocks later, `cs_n` rises HALF_DIV·(16N+2) clocks later, and `busy` falls HALF_DIV·(16N+4) clocks later. After the write, the bench samples `sck`, `cs_n` and `busy` once per falling edge of `clk` and records the index of each first change, then compares those indices with the formulas. Sent bytes, the number of clock edges and the updated data word are checked once `busy` has fallen. At that point every result has settled, and the next write cannot disturb them.

// File: rtl/spi_eng_pkg.sv
// Shared constants and state encoding for the SPI flash command engine.
// Assumes a command word of one opcode byte plus ADDR_BYTES address bytes.
package spi_eng_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_BITS,
        ST_TRAIL,
        ST_GAP
    } eng_state_t;

    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_CTL  = 2'd2;

    localparam int CTL_START_BIT = 0;
    localparam int CTL_TX_LSB    = 8;
    localparam int CTL_TX_W      = 4;
    localparam int CTL_RX_LSB    = 16;
    localparam int CTL_RX_W      = 3;

    localparam int ADDR_BYTES = 3;
    localparam int DATA_BYTES = 4;

endpackage

// File: rtl/spi_tick_gen.sv
// Half-period tick generator: while run is high, pulses tick once every
// HALF_DIV system clocks. The count restarts from zero whenever run is low.
module spi_tick_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    // Divide the system clock down to SPI half periods.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)    cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + CW'(1);
    end

    assign tick = run && (cnt_q == LAST);
endmodule

// File: rtl/spi_tx_byte_sel.sv
// Outgoing byte selector: maps a byte index onto the fixed send order
// (opcode, address MSB first, data LSB byte first). Index values past the
// last slot return zero. Purely combinational.
module spi_tx_byte_sel #(
    parameter int ADDR_BYTES = 3,
    parameter int DATA_BYTES = 4,
    parameter int IW         = 4
) (
    input  logic [8+8*ADDR_BYTES-1:0] cmd,
    input  logic [8*DATA_BYTES-1:0]   data,
    input  logic [IW-1:0]             idx,
    output logic [7:0]                tx_byte
);
    localparam int NB = 1 + ADDR_BYTES + DATA_BYTES;

    logic [7:0] slot [NB];

    assign slot[0] = cmd[7:0];

    for (genvar a = 0; a < ADDR_BYTES; a++) begin : g_addr
        assign slot[1+a] = cmd[8*(ADDR_BYTES-a) +: 8];
    end

    for (genvar d = 0; d < DATA_BYTES; d++) begin : g_data
        assign slot[1+ADDR_BYTES+d] = data[8*d +: 8];
    end

    // Pick the slot addressed by idx.
    always_comb begin
        tx_byte = 8'h00;
        for (int i = 0; i < NB; i++) begin
            if (idx == IW'(i)) tx_byte = slot[i];
        end
    end
endmodule

// File: rtl/spi_shift_core.sv
// Mode-0 shift sequencer. On launch it lowers chip select, waits one SPI
// clock, sends tx_cnt bytes taken from tx_byte (indexed by byte_idx), then
// captures rx_cnt bytes. It raises chip select half a clock after the last
// falling edge and stays busy for one more SPI clock. Assumes tx_cnt >= 1.
module spi_shift_core
    import spi_eng_pkg::*;
#(
    parameter int TXW = 4,
    parameter int RXW = 3,
    parameter int IW  = 4,
    parameter int LW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           launch,
    input  logic [TXW-1:0] tx_cnt,
    input  logic [RXW-1:0] rx_cnt,
    input  logic [7:0]     tx_byte,
    input  logic           miso,
    output logic [IW-1:0]  byte_idx,
    output logic           sck,
    output logic           cs_n,
    output logic           mosi,
    output logic           busy,
    output logic           rx_valid,
    output logic [7:0]     rx_byte,
    output logic [LW-1:0]  rx_lane
);
    eng_state_t     state_q;
    logic           sck_q, csn_q, ph_q, rxv_q;
    logic [2:0]     bit_q;
    logic [IW-1:0]  byte_q;
    logic [TXW-1:0] txn_q;
    logic [RXW-1:0] rxn_q;
    logic [6:0]     sh_q;
    logic [7:0]     rxb_q;
    logic [LW-1:0]  lane_q;

    logic          in_rx;
    logic [IW-1:0] last_idx;

    assign in_rx    = byte_q >= IW'(txn_q);
    assign last_idx = IW'(txn_q) + IW'(rxn_q) - IW'(1);

    // Step the transaction through its phases on SPI half-period ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sck_q   <= 1'b0;
            csn_q   <= 1'b1;
            ph_q    <= 1'b0;
            rxv_q   <= 1'b0;
            bit_q   <= 3'd7;
            byte_q  <= '0;
            txn_q   <= TXW'(1);
            rxn_q   <= '0;
            sh_q    <= '0;
            rxb_q   <= '0;
            lane_q  <= '0;
        end else begin
            rxv_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (launch) begin
                        state_q <= ST_LEAD;
                        csn_q   <= 1'b0;
                        ph_q    <= 1'b0;
                        bit_q   <= 3'd7;
                        byte_q  <= '0;
                        txn_q   <= tx_cnt;
                        rxn_q   <= rx_cnt;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        if (ph_q) begin
                            ph_q    <= 1'b0;
                            sck_q   <= 1'b1;
                            state_q <= ST_BITS;
                        end else begin
                            ph_q <= 1'b1;
                        end
                    end
                end
                ST_BITS: begin
                    if (tick) begin
                        if (!sck_q) begin
                            sck_q <= 1'b1;
                            if (in_rx) begin
                                sh_q <= {sh_q[5:0], miso};
                                if (bit_q == 3'd0) begin
                                    rxv_q  <= 1'b1;
                                    rxb_q  <= {sh_q, miso};
                                    lane_q <= LW'(byte_q - IW'(txn_q));
                                end
                            end
                        end else begin
                            sck_q <= 1'b0;
                            if (bit_q == 3'd0) begin
                                bit_q <= 3'd7;
                                if (byte_q == last_idx) state_q <= ST_TRAIL;
                                else                    byte_q  <= byte_q + IW'(1);
                            end else begin
                                bit_q <= bit_q - 3'd1;
                            end
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        csn_q   <= 1'b1;
                        ph_q    <= 1'b0;
                        state_q <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (ph_q) begin
                            ph_q    <= 1'b0;
                            state_q <= ST_IDLE;
                        end else begin
                            ph_q <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign byte_idx = byte_q;
    assign sck      = sck_q;
    assign cs_n     = csn_q;
    assign mosi     = in_rx ? 1'b0 : tx_byte[bit_q];
    assign busy     = (state_q != ST_IDLE);
    assign rx_valid = rxv_q;
    assign rx_byte  = rxb_q;
    assign rx_lane  = lane_q;
endmodule

// File: rtl/spi_flash_engine.sv
// SPI flash command engine top. Holds the command and data words, limits
// the byte counts taken from the control write, and starts the shift core.
// Received bytes are written back into data lanes. All writes are
// dropped while a transaction runs.
module spi_flash_engine
    import spi_eng_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] cmd_o,
    output logic [31:0] data_o,
    output logic        busy,
    output logic        sck,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso
);
    localparam int MAX_TX = 1 + ADDR_BYTES + DATA_BYTES;
    localparam int MAX_RX = DATA_BYTES;
    localparam int TXW    = $clog2(MAX_TX + 1);
    localparam int RXW    = $clog2(MAX_RX + 1);
    localparam int IW     = $clog2(MAX_TX + MAX_RX);
    localparam int LW     = (MAX_RX > 1) ? $clog2(MAX_RX) : 1;

    logic                launch, tick, rx_valid;
    logic [CTL_TX_W-1:0] tx_raw;
    logic [CTL_RX_W-1:0] rx_raw;
    logic [TXW-1:0]      tx_cnt;
    logic [RXW-1:0]      rx_cnt;
    logic [IW-1:0]       byte_idx;
    logic [7:0]          tx_byte, rx_byte;
    logic [LW-1:0]       rx_lane;
    logic [31:0]         cmd_q;
    logic [7:0]          lane_q [DATA_BYTES];
    logic [31:0]         data_w;

    assign launch = wr_en && (wr_sel == SEL_CTL) && wr_data[CTL_START_BIT] && !busy;
    assign tx_raw = wr_data[CTL_TX_LSB +: CTL_TX_W];
    assign rx_raw = wr_data[CTL_RX_LSB +: CTL_RX_W];

    // Limit the requested counts to what the byte layout can hold.
    always_comb begin
        if (tx_raw == '0)               tx_cnt = TXW'(1);
        else if (int'(tx_raw) > MAX_TX) tx_cnt = TXW'(MAX_TX);
        else                            tx_cnt = TXW'(tx_raw);
        if (int'(rx_raw) > MAX_RX)      rx_cnt = RXW'(MAX_RX);
        else                            rx_cnt = RXW'(rx_raw);
    end

    // Command word: loaded only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       cmd_q <= '0;
        else if (wr_en && (wr_sel == SEL_CMD) && !busy)   cmd_q <= wr_data;
    end

    for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
        // Data lane g: loaded by a write while idle, replaced by reply byte g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q[g] <= 8'h00;
            else if (wr_en && (wr_sel == SEL_DATA) && !busy)
                lane_q[g] <= wr_data[8*g +: 8];
            else if (rx_valid && (rx_lane == LW'(g)))
                lane_q[g] <= rx_byte;
        end
        assign data_w[8*g +: 8] = lane_q[g];
    end

    spi_tick_gen #(
        .HALF_DIV (HALF_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    spi_tx_byte_sel #(
        .ADDR_BYTES (ADDR_BYTES),
        .DATA_BYTES (DATA_BYTES),
        .IW         (IW)
    ) u_sel (
        .cmd     (cmd_q),
        .data    (data_w),
        .idx     (byte_idx),
        .tx_byte (tx_byte)
    );

    spi_shift_core #(
        .TXW (TXW),
        .RXW (RXW),
        .IW  (IW),
        .LW  (LW)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .launch   (launch),
        .tx_cnt   (tx_cnt),
        .rx_cnt   (rx_cnt),
        .tx_byte  (tx_byte),
        .miso     (miso),
        .byte_idx (byte_idx),
        .sck      (sck),
        .cs_n     (cs_n),
        .mosi     (mosi),
        .busy     (busy),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rx_lane  (rx_lane)
    );

    assign cmd_o  = cmd_q;
    assign data_o = data_w;
endmodule

// File: rtl/spi_flash_engine_chk.sv
// Protocol checker for spi_flash_engine, attached through bind. It keeps
// its own count of sck rising edges and compares that count with the
// limited byte counts taken from each accepted start.
module spi_flash_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic [31:0] wr_data,
    input logic [31:0] cmd_o,
    input logic        busy,
    input logic        sck,
    input logic        cs_n,
    input logic        mosi
);
    logic accept;
    logic sck_d;
    int   rises, exp_bits, txc, rxc;

    assign accept = wr_en && (wr_sel == 2'd2) && wr_data[0] && !busy;

    // Model of the count limits, used only to predict edge totals.
    always_comb begin
        txc = int'(wr_data[11:8]);
        if (txc == 0) txc = 1;
        if (txc > 8)  txc = 8;
        rxc = int'(wr_data[18:16]);
        if (rxc > 4)  rxc = 4;
    end

    // Count sck rises since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d    <= 1'b0;
            rises    <= 0;
            exp_bits <= 0;
        end else begin
            sck_d <= sck;
            if (accept) begin
                rises    <= 0;
                exp_bits <= 8 * (txc + rxc);
            end else if (sck && !sck_d) begin
                rises <= rises + 1;
            end
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> (cs_n && !sck && !busy));
    p_start_r3:      assert property (@(posedge clk) disable iff (!rst_n) accept |=> (busy && !cs_n && !sck));
    p_sck_idle_r7:   assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
    p_mosi_hold_r7:  assert property (@(posedge clk) disable iff (!rst_n) (sck && $past(sck)) |-> $stable(mosi));
    p_cs_busy_r8:    assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n);
    p_gap_r8:        assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> busy);
    p_cmd_hold_r9:   assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(cmd_o));
    p_bit_total_r10: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> (rises == exp_bits));
endmodule

bind spi_flash_engine spi_flash_engine_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .cmd_o   (cmd_o),
    .busy    (busy),
    .sck     (sck),
    .cs_n    (cs_n),
    .mosi    (mosi)
);

// File: tb/spi_flash_engine_test.sv
// Sweeps every raw send/receive count field value. A small flash model
// records mosi and replies with computed bytes.
module spi_flash_engine_test;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        miso;
    logic [31:0] cmd_o, data_o;
    logic        busy, sck, cs_n, mosi;

    always #2 clk = ~clk;

    spi_flash_engine #(.HALF_DIV(HALF)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cmd_o   (cmd_o),
        .data_o  (data_o),
        .busy    (busy),
        .sck     (sck),
        .cs_n    (cs_n),
        .mosi    (mosi),
        .miso    (miso)
    );

    int         total = 0;
    int         bad = 0;
    bit         finished = 0;
    int         nr = 0;
    logic [7:0] cap [12];
    int         exp_txc = 1;
    logic [7:0] rxpat [4];

    // Flash model: record mosi on sck rises; count restarts at select.
    always @(negedge cs_n or posedge sck) begin
        if (sck) begin
            if (nr < 96) cap[nr/8][7-(nr%8)] = mosi;
            nr = nr + 1;
        end else begin
            nr = 0;
        end
    end

    // Flash model reply: bit index nr of the reply stream after the send phase.
    always_comb begin
        miso = 1'b0;
        if (nr >= 8*exp_txc && (nr - 8*exp_txc) < 32)
            miso = rxpat[(nr - 8*exp_txc)/8][7-(nr%8)];
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int clamp_tx(input int raw);
        return (raw == 0) ? 1 : ((raw > 8) ? 8 : raw);
    endfunction

    function automatic int clamp_rx(input int raw);
        return (raw > 4) ? 4 : raw;
    endfunction

    function automatic logic [7:0] exp_byte(input int k, input logic [31:0] c, input logic [31:0] d);
        if (k == 0)     return c[7:0];
        else if (k < 4) return c[8*(4-k) +: 8];
        else            return d[8*(k-4) +: 8];
    endfunction

    function automatic logic [31:0] ctl_word(input int tx_raw, input int rx_raw);
        return {13'd0, 3'(rx_raw), 4'd0, 4'(tx_raw), 7'd0, 1'b1};
    endfunction

    // Wait out a transaction, noting first sck high and first cs_n high sample.
    // With inject set, write attempts are made while busy.
    task automatic wait_done(input bit inject, output int cyc, output int first_sck, output int cs_up);
        cyc = 0; first_sck = -1; cs_up = -1;
        while (busy && cyc < 20000) begin
            if (sck && first_sck < 0) first_sck = cyc;
            if (cs_n && cs_up < 0) cs_up = cyc;
            if (inject) begin
                if (cyc == 10) begin wr_en = 1'b1; wr_sel = 2'd2; wr_data = ctl_word(8, 4); end
                if (cyc == 11) begin wr_sel = 2'd0; wr_data = 32'hDEAD_BEEF; end
                if (cyc == 12) begin wr_sel = 2'd1; wr_data = 32'h0BAD_F00D; end
                if (cyc == 13) wr_en = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic run_txn(input int tx_raw, input int rx_raw, input logic [31:0] c,
                           input logic [31:0] d, input bit inject);
        int          txc, rxc, n, cyc, first_sck, cs_up;
        logic [31:0] expd;
        txc = clamp_tx(tx_raw);
        rxc = clamp_rx(rx_raw);
        n = txc + rxc;
        exp_txc = txc;
        for (int j = 0; j < 4; j++) rxpat[j] = 8'(8'h35 + tx_raw*16 + rx_raw*4 + j*29);
        wr(2'd0, c);
        wr(2'd1, d);
        wr(2'd2, ctl_word(tx_raw, rx_raw));
        check("R3", "busy after start", busy, 1);
        check("R3", "cs_n after start", cs_n, 0);
        wait_done(inject, cyc, first_sck, cs_up);
        check("R8", "first sck rise cycle", first_sck, 2*HALF);
        check("R8", "cs_n release cycle", cs_up, HALF*(16*n+2));
        check("R8", "busy length", cyc, HALF*(16*n+4));
        check("R10", "sck rising edges", nr, 8*n);
        for (int k = 0; k < txc; k++)
            check(tx_raw > 8 || tx_raw == 0 ? "R5" : "R4", "sent byte", cap[k], exp_byte(k, c, d));
        for (int k = txc; k < n; k++)
            check("R6", "mosi low in reply phase", cap[k], 0);
        for (int j = 0; j < 4; j++)
            expd[8*j +: 8] = (j < rxc) ? rxpat[j] : d[8*j +: 8];
        check(inject ? "R9" : "R6", "data word after reply", data_o, expd);
        check(inject ? "R9" : "R2", "command word kept", cmd_o, c);
    endtask

    initial begin
        logic [31:0] c, d;
        repeat (5) @(negedge clk);
        check("R1", "cs_n in reset", cs_n, 1);
        check("R1", "sck in reset", sck, 0);
        check("R1", "busy in reset", busy, 0);
        check("R1", "cmd word in reset", cmd_o, 0);
        check("R1", "data word in reset", data_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        wr(2'd0, 32'h1122_3344);
        check("R2", "command write", cmd_o, 32'h1122_3344);
        wr(2'd1, 32'h5566_7788);
        check("R2", "data write", data_o, 32'h5566_7788);
        wr(2'd3, 32'hFFFF_FFFF);
        check("R2", "select 3 leaves command", cmd_o, 32'h1122_3344);
        check("R2", "select 3 leaves data", data_o, 32'h5566_7788);
        check("R2", "select 3 starts nothing", busy, 0);

        for (int tx = 0; tx < 16; tx++) begin
            for (int rx = 0; rx < 8; rx++) begin
                c = 32'h5A00_0000 ^ (tx * 32'h0103_0507) ^ (rx * 32'h1020_4080);
                d = {c[15:0], c[31:16]} ^ 32'hC3C3_3C3C;
                run_txn(tx, rx, c, d, 1'b0);
            end
        end

        // R9: start, command and data writes during a transaction are dropped.
        run_txn(3, 2, 32'hA1B2_C3D4, 32'h9988_7766, 1'b1);
        check("R9", "no restart after ignored start", busy, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule